// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps two event counters for an Ethernet MAC and makes them visible on a small register bus. The receive datapath gives it one pulse per finished frame, with the frame length, the error flags and a flag that marks a pause frame. The transmit datapath gives it one pulse per finished transmission, with underrun and retry-limit flags. The block decides which events qualify and counts them. It does not parse frames or compute checksums.

Software reads a counter to collect it. The read clears the counter as a side effect, so software should poll often enough that a counter does not reach its ceiling. A counter that reaches its ceiling stays there until it is read. Three control inputs shape the counting. One allows receive-side counting. One allows software to preload the counters. One widens the accepted frame length for oversized frames.

Top module: `mac_stat_bank`

## Requirements
- R1: A read of a counter returns its current value, and the counter is zero on the following cycle unless an event arrives in the same cycle.
- R2: A counter that reaches all ones holds there and does not wrap. The pause counter ceiling is 0xFFFF and the transmit counter ceiling is 0xFFFFFF.
- R3: The pause counter does not change on received frames while `rx_enable` is low.
- R4: A bus write loads the addressed counter with the low bits of `reg_wdata` only while `stat_wr_en` is high. Otherwise the write is ignored.
- R5: The 16-bit pause counter counts received pause frames whose length is from 64 to 1518 bytes inclusive. Frames of 63 or 1519 bytes are not counted when `jumbo_en` is low.
- R6: While `jumbo_en` is high, the upper length bound becomes 1536 inclusive. A 1537-byte frame is still rejected.
- R7: A received frame with an FCS, alignment or symbol error is not counted. A frame without `rx_pause` is not counted.
- R8: The 24-bit transmit counter adds one per `tx_done` pulse that has neither `tx_underrun` nor `tx_retry_limit` set.
- R9: When a read and a qualifying event hit a counter in the same cycle, the read returns the old value and the counter becomes 1.
- R10: When a permitted write and a qualifying event hit a counter in the same cycle, the counter takes the written value.
- R11: Offset 0x00 reads the pause counter and offset 0x04 reads the transmit counter. Bits above the counter width read as zero. Any other offset reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_enable | input | 1 | Allows receive-side counting |
| stat_wr_en | input | 1 | Allows software writes to the counters |
| jumbo_en | input | 1 | Raises the upper length bound to 1536 |
| rx_done | input | 1 | One-cycle pulse when a received frame ends |
| rx_len | input | LEN_W | Length of the received frame in bytes |
| rx_pause | input | 1 | Marks the received frame as a pause frame |
| rx_fcs_err | input | 1 | The received frame has an FCS error |
| rx_align_err | input | 1 | The received frame has an alignment error |
| rx_sym_err | input | 1 | The received frame has a symbol error |
| tx_done | input | 1 | One-cycle pulse when a transmission ends |
| tx_underrun | input | 1 | The transmission had an underrun |
| tx_retry_limit | input | 1 | The transmission ran out of retries |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_rd | input | 1 | Read strobe. Data is valid in the same cycle |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when no read is in progress |

## Verification
The embedded assertions check these rules on every cycle:
- saturation without wrap;
- clear after a read;
- the read-plus-event result of 1;
- write priority;
- the frozen pause counter while receive is disabled;
- the frozen transmit counter on failed transmissions;
- zero upper bits and unmapped offsets.

Only the bench's scenarios show the following:
- the exact length-window edges at 63, 64, 1518, 1519, 1536 and 1537 bytes;
- the effect of each error flag;
- that writes are ignored without the write-enable;
- the full sequence of values that software collects.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

  // Register offsets. Software depends on these positions.
  localparam logic [7:0] OFS_PAUSE = 8'h00;
  localparam logic [7:0] OFS_TXOK  = 8'h04;

  // Frame length window, in bytes.
  localparam int LEN_MIN     = 64;
  localparam int LEN_MAX_STD = 1518;
  localparam int LEN_MAX_EXT = 1536;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PAUSE = 2'd1,
    SEL_TXOK  = 2'd2
  } stat_sel_e;

endpackage

// File: rtl/mac_stat_rx_qual.sv
module mac_stat_rx_qual
  import mac_stat_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             rx_enable,
  input  logic             jumbo_en,
  input  logic             rx_done,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_pause,
  input  logic             rx_fcs_err,
  input  logic             rx_align_err,
  input  logic             rx_sym_err,
  output logic             good_pause
);

  localparam logic [LEN_W-1:0] LO_BOUND  = LEN_W'(LEN_MIN);
  localparam logic [LEN_W-1:0] HI_STD    = LEN_W'(LEN_MAX_STD);
  localparam logic [LEN_W-1:0] HI_EXT    = LEN_W'(LEN_MAX_EXT);

  logic [LEN_W-1:0] hi_bound;
  logic             len_ok;
  logic             err_any;

  always_comb begin
    hi_bound = jumbo_en ? HI_EXT : HI_STD;
    len_ok   = (rx_len >= LO_BOUND) && (rx_len <= hi_bound);
    err_any  = rx_fcs_err | rx_align_err | rx_sym_err;
    good_pause = rx_done & rx_enable & rx_pause & ~err_any & len_ok;
  end

endmodule

// File: rtl/mac_stat_tx_qual.sv
module mac_stat_tx_qual (
  input  logic tx_done,
  input  logic tx_underrun,
  input  logic tx_retry_limit,
  output logic tx_ok
);

  always_comb begin
    tx_ok = tx_done & ~tx_underrun & ~tx_retry_limit;
  end

endmodule

// File: rtl/mac_stat_decode.sv
module mac_stat_decode
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              stat_wr_en,
  output stat_sel_e         sel,
  output logic              rd_pause,
  output logic              rd_txok,
  output logic              wr_pause,
  output logic              wr_txok
);

  localparam logic [ADDR_W-1:0] A_PAUSE = ADDR_W'(OFS_PAUSE);
  localparam logic [ADDR_W-1:0] A_TXOK  = ADDR_W'(OFS_TXOK);

  logic wr_ok;

  always_comb begin
    if (reg_addr == A_PAUSE)      sel = SEL_PAUSE;
    else if (reg_addr == A_TXOK)  sel = SEL_TXOK;
    else                          sel = SEL_NONE;
    wr_ok    = reg_wr & stat_wr_en;
    rd_pause = reg_rd & (sel == SEL_PAUSE);
    rd_txok  = reg_rd & (sel == SEL_TXOK);
    wr_pause = wr_ok  & (sel == SEL_PAUSE);
    wr_txok  = wr_ok  & (sel == SEL_TXOK);
  end

endmodule

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Next-state logic. A write wins, then a clearing read, then an increment.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (wr) begin
      cnt_d  = wdata;
      cnt_en = 1'b1;
    end else if (clr) begin
      cnt_d  = inc ? W'(1) : '0;
      cnt_en = 1'b1;
    end else if (inc && (cnt_q != CMAX)) begin
      cnt_d  = cnt_q + W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX) && inc && !clr && !wr |=> (cnt_q == CMAX));

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !wr |=> (cnt_q >= $past(cnt_q)));

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc && !wr |=> (cnt_q == '0));

  // R9
  clr_inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc && !wr |=> (cnt_q == W'(1)));

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LEN_W   = 14,
  parameter int PAUSE_W = 16,
  parameter int TXOK_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              stat_wr_en,
  input  logic              jumbo_en,
  input  logic              rx_done,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_pause,
  input  logic              rx_fcs_err,
  input  logic              rx_align_err,
  input  logic              rx_sym_err,
  input  logic              tx_done,
  input  logic              tx_underrun,
  input  logic              tx_retry_limit,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_PAUSE = ADDR_W'(OFS_PAUSE);
  localparam logic [ADDR_W-1:0] A_TXOK  = ADDR_W'(OFS_TXOK);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic          good_pause;
  logic          tx_ok;
  stat_sel_e     sel;
  logic          rd_pause, rd_txok, wr_pause, wr_txok;
  logic [PAUSE_W-1:0] pause_cnt;
  logic [TXOK_W-1:0]  txok_cnt;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:PAUSE_W < TXOK_W ? TXOK_W : PAUSE_W];

  mac_stat_rx_qual #(.LEN_W(LEN_W)) i_rx_qual (
    .rx_enable   (rx_enable),
    .jumbo_en    (jumbo_en),
    .rx_done     (rx_done),
    .rx_len      (rx_len),
    .rx_pause    (rx_pause),
    .rx_fcs_err  (rx_fcs_err),
    .rx_align_err(rx_align_err),
    .rx_sym_err  (rx_sym_err),
    .good_pause  (good_pause)
  );

  mac_stat_tx_qual i_tx_qual (
    .tx_done       (tx_done),
    .tx_underrun   (tx_underrun),
    .tx_retry_limit(tx_retry_limit),
    .tx_ok         (tx_ok)
  );

  mac_stat_decode #(.ADDR_W(ADDR_W)) i_decode (
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .stat_wr_en(stat_wr_en),
    .sel       (sel),
    .rd_pause  (rd_pause),
    .rd_txok   (rd_txok),
    .wr_pause  (wr_pause),
    .wr_txok   (wr_txok)
  );

  mac_stat_ctr #(.W(PAUSE_W)) i_pause_ctr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .inc  (good_pause),
    .clr  (rd_pause),
    .wr   (wr_pause),
    .wdata(reg_wdata[PAUSE_W-1:0]),
    .cnt  (pause_cnt)
  );

  mac_stat_ctr #(.W(TXOK_W)) i_txok_ctr (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .inc  (tx_ok),
    .clr  (rd_txok),
    .wr   (wr_txok),
    .wdata(reg_wdata[TXOK_W-1:0]),
    .cnt  (txok_cnt)
  );

  // Read mux. Data is the value before the clearing edge.
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_PAUSE: reg_rdata[PAUSE_W-1:0] = pause_cnt;
        SEL_TXOK:  reg_rdata[TXOK_W-1:0]  = txok_cnt;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R3
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_enable && !(reg_rd && reg_addr == A_PAUSE) &&
    !(reg_wr && stat_wr_en && reg_addr == A_PAUSE) |=> $stable(pause_cnt));

  // R8
  tx_fail_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_done || tx_underrun || tx_retry_limit) &&
    !(reg_rd && reg_addr == A_TXOK) &&
    !(reg_wr && stat_wr_en && reg_addr == A_TXOK) |=> $stable(txok_cnt));

  // R4
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !stat_wr_en && !rx_done && !reg_rd |=> $stable(pause_cnt));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rd && reg_addr != A_PAUSE && reg_addr != A_TXOK |-> reg_rdata == '0);

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rd && reg_addr == A_PAUSE |-> reg_rdata[DATA_W-1:PAUSE_W] == '0);

endmodule

// File: tb/test_mac_stat_bank.sv
module test_mac_stat_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_enable, stat_wr_en, jumbo_en;
  logic        rx_done, rx_pause, rx_fcs_err, rx_align_err, rx_sym_err;
  logic [13:0] rx_len;
  logic        tx_done, tx_underrun, tx_retry_limit;
  logic [7:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  mac_stat_bank i_mac_stat_bank (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .stat_wr_en(stat_wr_en),
    .jumbo_en(jumbo_en), .rx_done(rx_done), .rx_len(rx_len), .rx_pause(rx_pause),
    .rx_fcs_err(rx_fcs_err), .rx_align_err(rx_align_err), .rx_sym_err(rx_sym_err),
    .tx_done(tx_done), .tx_underrun(tx_underrun), .tx_retry_limit(tx_retry_limit),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] m_pause = 0;
  logic [31:0] m_tx = 0;

  // Monitor: compares every read against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  function automatic logic [31:0] sat(logic [31:0] v, logic [31:0] mx);
    return (v == mx) ? mx : v + 1;
  endfunction

  function automatic bit rx_good(int len, bit p, bit f, bit a, bit s);
    int hi;
    hi = jumbo_en ? 1536 : 1518;
    return rx_enable && p && !f && !a && !s && len >= 64 && len <= hi;
  endfunction

  task automatic step();
    @(posedge clk); #1;
    rx_done = 0; tx_done = 0; reg_rd = 0; reg_wr = 0;
    rx_fcs_err = 0; rx_align_err = 0; rx_sym_err = 0; rx_pause = 0;
    tx_underrun = 0; tx_retry_limit = 0;
  endtask

  task automatic set_rx(int len, bit p, bit f, bit a, bit s);
    rx_done = 1; rx_len = 14'(len); rx_pause = p;
    rx_fcs_err = f; rx_align_err = a; rx_sym_err = s;
  endtask

  task automatic rx_frame(int len, bit p, bit f, bit a, bit s);
    set_rx(len, p, f, a, s);
    if (rx_good(len, p, f, a, s)) m_pause = sat(m_pause, 32'hFFFF);
    step();
  endtask

  task automatic tx_frame(bit u, bit r);
    tx_done = 1; tx_underrun = u; tx_retry_limit = r;
    if (!u && !r) m_tx = sat(m_tx, 32'hFFFFFF);
    step();
  endtask

  task automatic push_read(logic [7:0] a, string tag);
    reg_rd = 1; reg_addr = a;
    tag_q.push_back(tag);
    if (a == 8'h00)      begin exp_q.push_back(m_pause); m_pause = 0; end
    else if (a == 8'h04) begin exp_q.push_back(m_tx);    m_tx = 0;    end
    else                 exp_q.push_back(32'h0);
  endtask

  task automatic read_reg(logic [7:0] a, string tag);
    push_read(a, tag);
    step();
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (stat_wr_en && a == 8'h00) m_pause = d & 32'hFFFF;
    if (stat_wr_en && a == 8'h04) m_tx = d & 32'hFFFFFF;
    step();
  endtask

  initial begin
    rst_n = 0; rx_enable = 0; stat_wr_en = 0; jumbo_en = 0;
    rx_done = 0; rx_len = 0; rx_pause = 0; rx_fcs_err = 0; rx_align_err = 0;
    rx_sym_err = 0; tx_done = 0; tx_underrun = 0; tx_retry_limit = 0;
    reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();

    // Reset state (R1, R11)
    read_reg(8'h00, "R1 reset pause");
    read_reg(8'h04, "R11 reset tx");

    // Length window and errors (R5, R7)
    rx_enable = 1;
    rx_frame(64, 1, 0, 0, 0);
    rx_frame(1518, 1, 0, 0, 0);
    rx_frame(63, 1, 0, 0, 0);
    rx_frame(1519, 1, 0, 0, 0);
    rx_frame(500, 1, 1, 0, 0);
    rx_frame(500, 1, 0, 1, 0);
    rx_frame(500, 1, 0, 0, 1);
    rx_frame(500, 0, 0, 0, 0);
    read_reg(8'h00, "R5 R7 window and errors");
    read_reg(8'h00, "R1 cleared after read");

    // Extended length (R6)
    jumbo_en = 1;
    rx_frame(1519, 1, 0, 0, 0);
    rx_frame(1536, 1, 0, 0, 0);
    rx_frame(1537, 1, 0, 0, 0);
    jumbo_en = 0;
    read_reg(8'h00, "R6 extended bound");

    // Receive gate (R3)
    rx_enable = 0;
    rx_frame(100, 1, 0, 0, 0);
    rx_frame(200, 1, 0, 0, 0);
    read_reg(8'h00, "R3 receive disabled");
    rx_enable = 1;

    // Transmit qualification (R8)
    tx_frame(0, 0); tx_frame(0, 0); tx_frame(0, 0);
    tx_frame(1, 0); tx_frame(0, 1); tx_frame(1, 1);
    read_reg(8'h04, "R8 tx ok count");

    // Write lock (R4)
    write_reg(8'h00, 32'h1234);
    write_reg(8'h04, 32'h5678);
    read_reg(8'h00, "R4 locked write pause");
    read_reg(8'h04, "R4 locked write tx");

    // Permitted write, upper bits dropped (R4, R11)
    stat_wr_en = 1;
    write_reg(8'h00, 32'hFFFF_FFFF);
    read_reg(8'h00, "R11 upper bits zero");

    // Saturation (R2)
    write_reg(8'h00, 32'hFFFE);
    rx_frame(64, 1, 0, 0, 0); rx_frame(64, 1, 0, 0, 0); rx_frame(64, 1, 0, 0, 0);
    read_reg(8'h00, "R2 pause saturates");
    write_reg(8'h04, 32'h00FF_FFFE);
    tx_frame(0, 0); tx_frame(0, 0); tx_frame(0, 0);
    read_reg(8'h04, "R2 tx saturates");

    // Read and event together (R9)
    rx_frame(80, 1, 0, 0, 0); rx_frame(80, 1, 0, 0, 0); rx_frame(80, 1, 0, 0, 0);
    push_read(8'h00, "R9 read with event");
    set_rx(80, 1, 0, 0, 0);
    m_pause = 1;
    step();
    read_reg(8'h00, "R9 event kept");

    // Write and event together (R10)
    reg_wr = 1; reg_addr = 8'h04; reg_wdata = 32'h55;
    tx_done = 1;
    m_tx = 32'h55;
    step();
    read_reg(8'h04, "R10 write wins tx");
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h77;
    set_rx(90, 1, 0, 0, 0);
    m_pause = 32'h77;
    step();
    read_reg(8'h00, "R10 write wins pause");

    // Unmapped offsets (R11)
    write_reg(8'h08, 32'hABCD);
    read_reg(8'h08, "R11 unmapped 08");
    read_reg(8'hFC, "R11 unmapped FC");
    read_reg(8'h00, "R11 unmapped write no effect");
    stat_wr_en = 0;

    repeat (3) step();
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule